// File: doc/BRIEF.md
# Boot Watchdog with Flash Failover

This block supervises a system's boot after power-on. As soon as the block leaves its own reset it runs a countdown measured in seconds. While that countdown runs it also watches the power-good input. If the countdown reaches zero, or power-good drops from high to low, the block drives an active-low system reset pulse. At the same moment it swaps which of two boot flashes is selected, so the next boot attempt uses the other copy. Power-good drops are tallied in a saturating counter.

Software ends supervision by pulsing the kick input, which marks the boot as successful. It sets the timeout through a small write port: a 4-bit value n selects n+1 seconds. A prescaler derives the one-second tick from the core clock, and its divisor is a parameter.

The control is a three-state machine:
- WATCH: the countdown is running. Kick moves it to DONE. Expiry or a power-good drop moves it to PULSE.
- PULSE: the system reset is driven low. When the pulse length is reached it returns to WATCH with a fresh countdown.
- DONE: the boot has succeeded and the countdown is stopped. A power-good drop moves it to PULSE.

Top module: `boot_supervisor`

## Requirements
- R1: After the block reset is released: sys_rst_n_o=1, flash_sel_o=0, fail_cnt_o=0, cfg_q_o=9, secs_left_o=10 and boot_done_o=0.
- R2: With timeout value n in cfg_q_o, sys_rst_n_o falls (n+1)*TICK_CLKS clocks after WATCH is entered. A write (cfg_wr_i=1 loads cfg_data_i) is visible on cfg_q_o at once but is only used at the next countdown reload.
- R3: Each reset pulse keeps sys_rst_n_o low for exactly RST_PULSE_CLKS clocks. A fresh countdown then starts in WATCH.
- R4: An expiry toggles flash_sel_o as the pulse starts and leaves fail_cnt_o unchanged.
- R5: A power-good drop in WATCH or DONE starts a reset pulse. A drop is pwrok_i sampled 1 and then 0 at two consecutive clock edges. In the cycle after the low sample, sys_rst_n_o=0, flash_sel_o has toggled, fail_cnt_o has risen by one and boot_done_o=0.
- R6: fail_cnt_o saturates at 255 and never wraps.
- R7: kick_i=1 in WATCH moves to DONE. There boot_done_o=1 and no expiry occurs however long the block waits. Kick has no effect in PULSE.
- R8: A power-good drop during a pulse is ignored. It causes no count, no extra toggle and no change to the pulse length.
- R9: In WATCH, secs_left_o starts at n+1 and falls by one every TICK_CLKS clocks.
- R10: When a power-good drop and a kick arrive in the same WATCH cycle, the failure wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low block reset |
| pwrok_i | input | 1 | Power-good status, synchronous |
| kick_i | input | 1 | Boot-success strobe from software |
| cfg_wr_i | input | 1 | Timeout register write strobe |
| cfg_data_i | input | TO_W | Timeout value to write (n gives n+1 s) |
| cfg_q_o | output | TO_W | Current timeout register |
| sys_rst_n_o | output | 1 | Active-low system reset pulse |
| flash_sel_o | output | 1 | Boot flash select (0 = primary) |
| fail_cnt_o | output | CNT_W | Saturating power-good failure count |
| secs_left_o | output | TO_W+1 | Seconds remaining in the countdown |
| boot_done_o | output | 1 | Boot marked successful, countdown stopped |

## Verification
Every one of the sixteen timeout values is programmed in turn. Each expiry interval is measured in clocks, so an off-by-one in the seconds encoding or in the prescaler shows up. The default value is measured first, with a write landing mid-count, which separates "written" from "applied at reload". Power-good drops are applied in WATCH, in DONE, during a pulse and together with a kick. These cases separate counting from ignoring and test priority. A run of more than 255 drops exposes wrap-around of the failure counter.

// File: rtl/bootsup_pkg.sv
package bootsup_pkg;
    typedef enum logic [1:0] {
        ST_WATCH = 2'd0,
        ST_PULSE = 2'd1,
        ST_DONE  = 2'd2
    } sup_state_e;
endpackage

// File: rtl/bootsup_tick.sv
module bootsup_tick #(
    parameter int TICK_CLKS = 34_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int PW = $clog2(TICK_CLKS + 1);
    localparam logic [PW-1:0] LAST = PW'(TICK_CLKS - 1);

    logic [PW-1:0] pcnt_q;

    assign tick = !clr && (pcnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pcnt_q <= '0;
        else if (clr || tick)
            pcnt_q <= '0;
        else
            pcnt_q <= pcnt_q + 1'b1;
    end
endmodule

// File: rtl/bootsup_countdown.sv
module bootsup_countdown #(
    parameter int SW       = 5,
    parameter int INIT_VAL = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [SW-1:0] load_val,
    input  logic          tick,
    output logic [SW-1:0] secs,
    output logic          expire
);
    logic [SW-1:0] secs_q;

    assign secs   = secs_q;
    assign expire = !load && tick && (secs_q == SW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            secs_q <= SW'(INIT_VAL);
        else if (load)
            secs_q <= load_val;
        else if (tick && secs_q != '0)
            secs_q <= secs_q - 1'b1;
    end
endmodule

// File: rtl/bootsup_satcnt.sv
module bootsup_satcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_q;

    assign cnt = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (inc && cnt_q != '1)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/bootsup_fsm.sv
module bootsup_fsm
    import bootsup_pkg::*;
#(
    parameter int RST_PULSE_CLKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwrok_i,
    input  logic kick_i,
    input  logic expire,
    output logic in_watch,
    output logic fail_evt,
    output logic sys_rst_n,
    output logic flash_sel,
    output logic boot_done
);
    localparam int RW = $clog2(RST_PULSE_CLKS + 1);
    localparam logic [RW-1:0] RLAST = RW'(RST_PULSE_CLKS - 1);

    sup_state_e    state_q, state_d;
    logic [RW-1:0] rcnt_q;
    logic          pwrok_q;
    logic          flash_q;
    logic          pwr_drop;
    logic          enter_pulse;

    assign pwr_drop = pwrok_q && !pwrok_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WATCH: begin
                if (pwr_drop)
                    state_d = ST_PULSE;
                else if (kick_i)
                    state_d = ST_DONE;
                else if (expire)
                    state_d = ST_PULSE;
            end
            ST_PULSE: begin
                if (rcnt_q == RLAST)
                    state_d = ST_WATCH;
            end
            ST_DONE: begin
                if (pwr_drop)
                    state_d = ST_PULSE;
            end
            default: state_d = ST_WATCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WATCH;
            rcnt_q  <= '0;
            pwrok_q <= 1'b0;
            flash_q <= 1'b0;
        end else begin
            state_q <= state_d;
            pwrok_q <= pwrok_i;
            rcnt_q  <= (state_q == ST_PULSE) ? rcnt_q + 1'b1 : '0;
            if (enter_pulse)
                flash_q <= !flash_q;
        end
    end

    always_comb begin
        in_watch    = (state_q == ST_WATCH);
        sys_rst_n   = (state_q != ST_PULSE);
        boot_done   = (state_q == ST_DONE);
        fail_evt    = (state_q != ST_PULSE) && pwr_drop;
        enter_pulse = (state_q != ST_PULSE) && (state_d == ST_PULSE);
        flash_sel   = flash_q;
    end
endmodule

// File: rtl/boot_supervisor.sv
module boot_supervisor #(
    parameter int TICK_CLKS      = 34_000_000,
    parameter int TO_W           = 4,
    parameter int TO_DEFAULT     = 9,
    parameter int RST_PULSE_CLKS = 16,
    parameter int CNT_W          = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwrok_i,
    input  logic             kick_i,
    input  logic             cfg_wr_i,
    input  logic [TO_W-1:0]  cfg_data_i,
    output logic [TO_W-1:0]  cfg_q_o,
    output logic             sys_rst_n_o,
    output logic             flash_sel_o,
    output logic [CNT_W-1:0] fail_cnt_o,
    output logic [TO_W:0]    secs_left_o,
    output logic             boot_done_o
);
    localparam int SW = TO_W + 1;

    logic [TO_W-1:0] cfg_q;
    logic            tick;
    logic            expire;
    logic            in_watch;
    logic            fail_evt;
    logic [SW-1:0]   reload_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_q <= TO_W'(TO_DEFAULT);
        else if (cfg_wr_i)
            cfg_q <= cfg_data_i;
    end

    assign reload_val = {1'b0, cfg_q} + SW'(1);
    assign cfg_q_o    = cfg_q;

    bootsup_tick #(.TICK_CLKS(TICK_CLKS)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!in_watch),
        .tick  (tick)
    );

    bootsup_countdown #(.SW(SW), .INIT_VAL(TO_DEFAULT + 1)) u_cd (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (!in_watch),
        .load_val (reload_val),
        .tick     (tick),
        .secs     (secs_left_o),
        .expire   (expire)
    );

    bootsup_fsm #(.RST_PULSE_CLKS(RST_PULSE_CLKS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwrok_i   (pwrok_i),
        .kick_i    (kick_i),
        .expire    (expire),
        .in_watch  (in_watch),
        .fail_evt  (fail_evt),
        .sys_rst_n (sys_rst_n_o),
        .flash_sel (flash_sel_o),
        .boot_done (boot_done_o)
    );

    bootsup_satcnt #(.W(CNT_W)) u_fail (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (fail_evt),
        .cnt   (fail_cnt_o)
    );
endmodule

// File: rtl/bootsup_chk.sv
module bootsup_chk #(
    parameter int TO_W           = 4,
    parameter int RST_PULSE_CLKS = 16,
    parameter int CNT_W          = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwrok_i,
    input logic             sys_rst_n_o,
    input logic             flash_sel_o,
    input logic [CNT_W-1:0] fail_cnt_o,
    input logic [TO_W:0]    secs_left_o,
    input logic             boot_done_o
);
    logic [15:0] low_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            low_cnt_q <= '0;
        else if (!sys_rst_n_o)
            low_cnt_q <= low_cnt_q + 1'b1;
        else
            low_cnt_q <= '0;
    end

    // R3
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(low_cnt_q) <= RST_PULSE_CLKS));

    // R5
    drop_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && sys_rst_n_o && $past(pwrok_i) && !pwrok_i) |=> !sys_rst_n_o);

    // R4
    flash_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_n_o) |-> (flash_sel_o != $past(flash_sel_o)));

    // R4
    flash_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(sys_rst_n_o) |-> $stable(flash_sel_o));

    // R6
    fail_cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_cnt_o == $past(fail_cnt_o)) ||
        (32'(fail_cnt_o) == 32'($past(fail_cnt_o)) + 1));

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done_o |=> (boot_done_o || !sys_rst_n_o));

    // R7
    done_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done_o |-> sys_rst_n_o);

    // R9
    secs_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_n_o |-> (secs_left_o != '0));
endmodule

bind boot_supervisor bootsup_chk #(
    .TO_W           (TO_W),
    .RST_PULSE_CLKS (RST_PULSE_CLKS),
    .CNT_W          (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwrok_i     (pwrok_i),
    .sys_rst_n_o (sys_rst_n_o),
    .flash_sel_o (flash_sel_o),
    .fail_cnt_o  (fail_cnt_o),
    .secs_left_o (secs_left_o),
    .boot_done_o (boot_done_o)
);

// File: tb/boot_supervisor_tb.sv
`timescale 1ns/1ps
module boot_supervisor_tb;
    localparam int TICK  = 8;
    localparam int PULSE = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwrok_i = 1'b1;
    logic       kick_i = 1'b0;
    logic       cfg_wr_i = 1'b0;
    logic [3:0] cfg_data_i = '0;
    logic [3:0] cfg_q_o;
    logic       sys_rst_n_o;
    logic       flash_sel_o;
    logic [7:0] fail_cnt_o;
    logic [4:0] secs_left_o;
    logic       boot_done_o;

    int compared = 0;
    int mismatched = 0;
    logic exp_flash = 1'b0;
    int exp_fail = 0;

    always #5 clk = ~clk;

    boot_supervisor #(
        .TICK_CLKS(TICK), .TO_W(4), .TO_DEFAULT(9),
        .RST_PULSE_CLKS(PULSE), .CNT_W(8)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .pwrok_i(pwrok_i), .kick_i(kick_i),
        .cfg_wr_i(cfg_wr_i), .cfg_data_i(cfg_data_i), .cfg_q_o(cfg_q_o),
        .sys_rst_n_o(sys_rst_n_o), .flash_sel_o(flash_sel_o),
        .fail_cnt_o(fail_cnt_o), .secs_left_o(secs_left_o),
        .boot_done_o(boot_done_o)
    );

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input int v);
        cfg_wr_i = 1'b1;
        cfg_data_i = 4'(v);
        @(negedge clk);
        cfg_wr_i = 1'b0;
    endtask

    // count posedges until sys_rst_n_o is seen low at a negedge
    task automatic measure_to_low(output int n, input int limit);
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (sys_rst_n_o && n < limit);
    endtask

    // count low samples until sys_rst_n_o is high again
    task automatic wait_pulse_end(output int lows);
        lows = 0;
        while (!sys_rst_n_o) begin
            lows++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int n;
        int lows;
        int early;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 sys_rst_n", int'(sys_rst_n_o), 1);
        check("R1 flash", int'(flash_sel_o), 0);
        check("R1 fail_cnt", int'(fail_cnt_o), 0);
        check("R1 cfg", int'(cfg_q_o), 9);
        check("R1 secs", int'(secs_left_o), 10);
        check("R1 boot_done", int'(boot_done_o), 0);

        // R2 default timeout, write mid-count applies only at reload
        write_cfg(15);
        check("R2 cfg readback", int'(cfg_q_o), 15);
        measure_to_low(n, 1000);
        check("R2 default timeout clocks", n + 1, 10 * TICK);
        exp_flash = ~exp_flash;
        check("R4 flash after expiry", int'(flash_sel_o), int'(exp_flash));
        check("R4 fail_cnt unchanged", int'(fail_cnt_o), 0);

        // R8 / R7: power drop and kick during the pulse are ignored
        pwrok_i = 1'b0;
        kick_i = 1'b1;
        @(negedge clk);
        pwrok_i = 1'b1;
        kick_i = 1'b0;
        wait_pulse_end(lows);
        check("R3 R8 pulse length", lows + 1, PULSE);
        check("R8 fail_cnt", int'(fail_cnt_o), 0);
        check("R8 flash", int'(flash_sel_o), int'(exp_flash));
        check("R7 kick in pulse", int'(boot_done_o), 0);

        // R2 new value applied after reload
        measure_to_low(n, 1000);
        check("R2 reloaded 16s", n, 16 * TICK);
        exp_flash = ~exp_flash;

        // R2 / R9 sweep all timeout values
        for (int v = 0; v < 16; v++) begin
            write_cfg(v);
            wait_pulse_end(lows);
            check("R9 secs at start", int'(secs_left_o), v + 1);
            check("R4 flash", int'(flash_sel_o), int'(exp_flash));
            early = 0;
            n = 0;
            do begin
                @(posedge clk);
                n++;
                @(negedge clk);
                if (n == TICK && v >= 1)
                    check("R9 secs after one tick", int'(secs_left_o), v);
            end while (sys_rst_n_o && n < 1000);
            check("R2 sweep timeout", n, (v + 1) * TICK);
            exp_flash = ~exp_flash;
        end
        check("R4 fail_cnt after sweep", int'(fail_cnt_o), 0);

        // R7 kick stops the countdown
        wait_pulse_end(lows);
        check("R3 pulse length", lows, PULSE);
        kick_i = 1'b1;
        @(negedge clk);
        kick_i = 1'b0;
        check("R7 boot_done", int'(boot_done_o), 1);
        early = 0;
        repeat (400) begin
            @(negedge clk);
            if (!sys_rst_n_o) early++;
        end
        check("R7 no expiry after kick", early, 0);
        check("R7 still done", int'(boot_done_o), 1);

        // R5 drop in DONE
        pwrok_i = 1'b0;
        @(negedge clk);
        pwrok_i = 1'b1;
        exp_flash = ~exp_flash;
        exp_fail = 1;
        check("R5 reset from done", int'(sys_rst_n_o), 0);
        check("R5 flash", int'(flash_sel_o), int'(exp_flash));
        check("R5 fail_cnt", int'(fail_cnt_o), exp_fail);
        check("R5 boot_done cleared", int'(boot_done_o), 0);
        wait_pulse_end(lows);

        // R10 drop and kick together
        @(negedge clk);
        pwrok_i = 1'b0;
        kick_i = 1'b1;
        @(negedge clk);
        pwrok_i = 1'b1;
        kick_i = 1'b0;
        exp_flash = ~exp_flash;
        exp_fail = 2;
        check("R10 failure wins", int'(sys_rst_n_o), 0);
        check("R10 fail_cnt", int'(fail_cnt_o), exp_fail);
        check("R10 boot_done", int'(boot_done_o), 0);
        wait_pulse_end(lows);

        // R6 saturation, R5 in WATCH
        for (int i = 0; i < 258; i++) begin
            pwrok_i = 1'b0;
            @(negedge clk);
            pwrok_i = 1'b1;
            exp_flash = ~exp_flash;
            if (exp_fail < 255) exp_fail++;
            check("R5 drop in watch", int'(sys_rst_n_o), 0);
            check("R6 fail_cnt", int'(fail_cnt_o), exp_fail);
            wait_pulse_end(lows);
        end
        check("R6 saturated", int'(fail_cnt_o), 255);
        check("R5 flash parity", int'(flash_sel_o), int'(exp_flash));

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule